// File: doc/BRIEF.md
# Multiply-Divide Issue Controller

This controller sits beside a multi-cycle integer multiply/divide datapath in an in-order pipeline and decides when an operation may enter it. Each request carries an instruction tag, a command (start or end), an operation kind (multiply or divide) and the 32-bit divisor operand. The arithmetic itself is done elsewhere. This block only accepts or refuses requests, times each operation and pulses `done_o` with the tag when the time is up.

The block holds a single operation slot. A start from a new tag is accepted only when the slot is empty and enough cycles have passed since the previous acceptance. That minimum spacing follows the kind of the previous operation and, for a divide, the magnitude class of its divisor. Divide latency is also set by the magnitude class. A start is reported complete in its own cycle, so the instruction moves on while the operation runs. The instruction then polls with end commands until the latency has run out, and the end that completes frees the slot.

Top module: `mdu_issue_ctrl`

## Requirements
- R1: After reset no slot is held and no minimum spacing applies: with no request `grant_o`, `complete_o` and `done_o` are 0, and the first start is accepted at once.
- R2: A divisor is classed by its highest nonzero byte: up to 0xFF gives the 10-cycle class, up to 0xFFFF the 18-cycle class, up to 0xFFFFFF the 26-cycle class, and anything larger the 34-cycle class. These are the default divide latencies.
- R3: A start (`req_cmd_i`=0) that is granted reports `complete_o`=1 in the same cycle.
- R4: `done_o` is high for exactly one cycle, in the L-th cycle after the cycle in which the start was accepted, where L is the latency of that operation. `done_tag_o` carries the owning tag in that cycle.
- R5: An end command (`req_cmd_i`=1) from the slot holder is granted. It reports `complete_o`=0 up to and including the `done_o` cycle, and `complete_o`=1 from the cycle after. The completing end frees the slot.
- R6: A repeated request from the tag that holds the slot is granted without restarting the operation. A repeated start reports complete, and `done_o` timing still counts from the first acceptance. A request with a different command only updates the stored command.
- R7: A start from a tag other than the holder is refused (`grant_o`=0) while the slot is occupied.
- R8: A start from a new tag is refused while fewer cycles than the repeat rate of the last accepted operation have passed since that acceptance. It is accepted exactly when that many cycles have passed. The default rates are 8 for multiply and 14/22/30/38 for the four divide classes.
- R9: A multiply (`req_div_i`=0) uses the multiply latency (default 4) and the multiply repeat rate, whatever the divisor value.
- R10: An end command from a tag that does not hold the slot is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_tag_i | input | TAG_W | Instruction tag of the request |
| req_cmd_i | input | 1 | 0 = start, 1 = end/poll |
| req_div_i | input | 1 | 1 = divide, 0 = multiply |
| req_divisor_i | input | DATA_W | Divisor operand, used to pick the size class |
| grant_o | output | 1 | Request accepted or served this cycle |
| complete_o | output | 1 | Requested step reports complete this cycle |
| done_o | output | 1 | One-cycle pulse when the latency expires |
| done_tag_o | output | TAG_W | Tag that owns the expiring operation |

## Verification
Two events can land in the same cycle: the latency expiry that raises `done_o`, and an end poll from the holder. The bench issues the poll exactly in the pulse cycle and expects a grant with `complete_o`=0 while `done_o` is high, then expects `complete_o`=1 on the poll that follows. The second overlap is a start from a new tag in a cycle where the slot is already free but the spacing window is still open. That start must be refused, and the same start one cycle after the window closes must be accepted.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  localparam int unsigned CNT_W = 8;
  localparam int unsigned NCLS  = 4;
  localparam int unsigned CLS_W = 2;

  typedef enum logic {
    CMD_START = 1'b0,
    CMD_END   = 1'b1
  } mdu_cmd_e;
endpackage

// File: rtl/mdu_div_class.sv
module mdu_div_class #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0]       divisor_i,
  output logic [mdu_pkg::CLS_W-1:0] cls_o
);
  localparam int unsigned NBYTE = DATA_W / 8;

  // class = index of highest nonzero byte
  always_comb begin
    cls_o = '0;
    for (int b = 1; b < NBYTE; b++) begin
      if (|divisor_i[b*8 +: 8]) cls_o = mdu_pkg::CLS_W'(b);
    end
  end
endmodule

// File: rtl/mdu_spacing.sv
module mdu_spacing #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         accept_i,
  input  logic [W-1:0] rate_i,
  output logic         open_o
);
  logic [W-1:0] wait_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= '0;
    end else if (accept_i) begin
      wait_q <= (rate_i == '0) ? '0 : rate_i - W'(1);
    end else if (wait_q != '0) begin
      wait_q <= wait_q - W'(1);
    end
  end

  assign open_o = (wait_q == '0);
endmodule

// File: rtl/mdu_latency.sv
module mdu_latency #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] lat_i,
  output logic         done_o,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= lat_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  assign done_o    = (cnt_q == W'(1));
  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/mdu_issue_ctrl.sv
module mdu_issue_ctrl
  import mdu_pkg::*;
#(
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned DATA_W = 32,
  parameter logic [CNT_W-1:0] MUL_LAT = 8'd4,
  parameter logic [CNT_W-1:0] MUL_RPT = 8'd8,
  parameter logic [NCLS-1:0][CNT_W-1:0] DIV_LAT = {8'd34, 8'd26, 8'd18, 8'd10},
  parameter logic [NCLS-1:0][CNT_W-1:0] DIV_RPT = {8'd38, 8'd30, 8'd22, 8'd14}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [TAG_W-1:0]  req_tag_i,
  input  logic              req_cmd_i,
  input  logic              req_div_i,
  input  logic [DATA_W-1:0] req_divisor_i,
  output logic              grant_o,
  output logic              complete_o,
  output logic              done_o,
  output logic [TAG_W-1:0]  done_tag_o
);
  logic             slot_v_q;
  logic [TAG_W-1:0] slot_tag_q;
  mdu_cmd_e         slot_cmd_q;

  logic [CLS_W-1:0] cls;
  logic [CNT_W-1:0] sel_lat, sel_rpt;
  logic             spacing_open, expired;
  logic             holder, new_ok, free_slot;
  mdu_cmd_e         cmd;

  assign cmd = mdu_cmd_e'(req_cmd_i);

  mdu_div_class #(.DATA_W(DATA_W)) u_class (
    .divisor_i (req_divisor_i),
    .cls_o     (cls)
  );

  assign sel_lat = req_div_i ? DIV_LAT[cls] : MUL_LAT;
  assign sel_rpt = req_div_i ? DIV_RPT[cls] : MUL_RPT;

  assign holder    = req_valid_i && slot_v_q && (req_tag_i == slot_tag_q);
  assign new_ok    = req_valid_i && !slot_v_q && spacing_open && (cmd == CMD_START);
  assign free_slot = holder && (cmd == CMD_END) && expired;

  assign grant_o    = holder || new_ok;
  assign complete_o = new_ok || (holder && ((cmd == CMD_START) || expired));

  mdu_spacing #(.W(CNT_W)) u_spacing (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (new_ok),
    .rate_i   (sel_rpt),
    .open_o   (spacing_open)
  );

  mdu_latency #(.W(CNT_W)) u_latency (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (new_ok),
    .lat_i     (sel_lat),
    .done_o    (done_o),
    .expired_o (expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_v_q   <= 1'b0;
      slot_tag_q <= '0;
      slot_cmd_q <= CMD_START;
    end else if (new_ok) begin
      slot_v_q   <= 1'b1;
      slot_tag_q <= req_tag_i;
      slot_cmd_q <= CMD_START;
    end else if (free_slot) begin
      slot_v_q   <= 1'b0;
      slot_cmd_q <= CMD_END;
    end else if (holder && (slot_cmd_q != cmd)) begin
      slot_cmd_q <= cmd;
    end
  end

  assign done_tag_o = slot_tag_q;
endmodule

// File: rtl/mdu_issue_ctrl_chk.sv
module mdu_issue_ctrl_chk #(
  parameter int unsigned TAG_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [TAG_W-1:0] req_tag_i,
  input logic             req_cmd_i,
  input logic             grant_o,
  input logic             complete_o,
  input logic             done_o,
  input logic             slot_v_q,
  input logic [TAG_W-1:0] slot_tag_q,
  input logic             new_ok,
  input logic [7:0]       sel_rpt
);
  logic [7:0] gap_q, rate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= 8'hFF;
      rate_q <= 8'd0;
    end else if (new_ok) begin
      gap_q  <= 8'd1;
      rate_q <= sel_rpt;
    end else if (gap_q != 8'hFF) begin
      gap_q  <= gap_q + 8'd1;
    end
  end

  AST_START_COMPLETES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && !req_cmd_i) |-> complete_o); // R3

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R4

  AST_END_NOT_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && req_valid_i && req_cmd_i) |-> !complete_o); // R5

  AST_BUSY_REFUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && slot_v_q && (req_tag_i != slot_tag_q)) |-> !grant_o); // R7

  AST_SPACING_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_ok |-> (gap_q >= rate_q)); // R8

  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o || complete_o) |-> req_valid_i); // R1
endmodule

bind mdu_issue_ctrl mdu_issue_ctrl_chk #(.TAG_W(TAG_W)) u_chk (.*);

// File: tb/tb_mdu_issue_ctrl.sv
module tb_mdu_issue_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_tag = '0;
  logic        req_cmd = 1'b0;
  logic        req_div = 1'b0;
  logic [31:0] req_divisor = '0;
  logic        grant, complete, done;
  logic [3:0]  done_tag;

  int checks = 0;
  int errors = 0;
  logic g_s, c_s, d_s;
  logic [3:0] dt_s;

  always #10 clk = ~clk;

  mdu_issue_ctrl dut (
    .clk_i (clk), .rst_ni (rst_ni),
    .req_valid_i (req_valid), .req_tag_i (req_tag), .req_cmd_i (req_cmd),
    .req_div_i (req_div), .req_divisor_i (req_divisor),
    .grant_o (grant), .complete_o (complete),
    .done_o (done), .done_tag_o (done_tag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive after negedge, sample before the next posedge
  task automatic step(input logic v, input logic [3:0] tg, input logic cm,
                      input logic dv, input logic [31:0] dd);
    @(negedge clk);
    req_valid = v; req_tag = tg; req_cmd = cm; req_div = dv; req_divisor = dd;
    #2;
    g_s = grant; c_s = complete; d_s = done; dt_s = done_tag;
    @(posedge clk);
  endtask

  task automatic idle();
    step(1'b0, 4'd0, 1'b0, 1'b0, 32'd0);
  endtask

  task automatic test_reset();
    idle();
    chk(!g_s && !c_s && !d_s, "R1 idle after reset", int'({g_s, c_s, d_s}), 0);
  endtask

  // one full operation; returns so the next call starts exactly at rpt
  task automatic run_op(input logic [3:0] tg, input logic dv, input logic [31:0] dd,
                        input int lat, input int rpt, input string lbl);
    step(1'b1, tg, 1'b0, dv, dd);
    chk(g_s, {lbl, " start accepted (R8 boundary)"}, int'(g_s), 1);
    chk(c_s, "R3 start completes at once", int'(c_s), 1);
    for (int i = 1; i <= lat; i++) begin
      idle();
      chk(d_s == (i == lat), {lbl, " R4 done timing"}, int'(d_s), int'(i == lat));
      if (i == lat) chk(dt_s == tg, "R4 done tag", int'(dt_s), int'(tg));
    end
    step(1'b1, tg, 1'b1, dv, dd);
    chk(g_s && c_s, "R5 end after expiry completes", int'({g_s, c_s}), 3);
    for (int i = lat + 2; i < rpt; i++) begin
      if (i == rpt - 1) begin
        step(1'b1, tg + 4'd1, 1'b0, 1'b0, 32'd0);
        chk(!g_s, {lbl, " R8 refused inside spacing"}, int'(g_s), 0);
      end else begin
        idle();
      end
    end
  endtask

  task automatic test_busy();
    step(1'b1, 4'd5, 1'b0, 1'b0, 32'hFFFF_FFFF);
    chk(g_s && c_s, "R9 multiply accepted", int'({g_s, c_s}), 3);
    step(1'b1, 4'd6, 1'b0, 1'b0, 32'd0);
    chk(!g_s, "R7 other tag refused while busy", int'(g_s), 0);
    step(1'b1, 4'd5, 1'b0, 1'b0, 32'd0);
    chk(g_s && c_s, "R6 repeat start served", int'({g_s, c_s}), 3);
    step(1'b1, 4'd6, 1'b1, 1'b0, 32'd0);
    chk(!g_s, "R10 end from non-holder refused", int'(g_s), 0);
    step(1'b1, 4'd5, 1'b1, 1'b0, 32'd0);
    chk(g_s && !c_s, "R5 end in done cycle not complete", int'({g_s, c_s}), 2);
    chk(d_s, "R6 done not restarted by repeat", int'(d_s), 1);
    step(1'b1, 4'd5, 1'b1, 1'b0, 32'd0);
    chk(g_s && c_s, "R5 poll after done completes", int'({g_s, c_s}), 3);
    step(1'b1, 4'd7, 1'b0, 1'b0, 32'd0);
    chk(!g_s, "R8 free slot but spacing open", int'(g_s), 0);
    idle();
    step(1'b1, 4'd7, 1'b0, 1'b0, 32'd0);
    chk(g_s, "R8 accepted at spacing boundary", int'(g_s), 1);
    for (int i = 1; i <= 4; i++) idle();
    step(1'b1, 4'd7, 1'b1, 1'b0, 32'd0);
    chk(c_s, "R9 multiply latency", int'(c_s), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    test_reset();
    run_op(4'd1, 1'b0, 32'h0000_0001, 4, 8, "R1 R9");
    run_op(4'd2, 1'b1, 32'h0000_00FF, 10, 14, "R2 c8");
    run_op(4'd3, 1'b1, 32'h0000_0100, 18, 22, "R2 c16lo");
    run_op(4'd4, 1'b1, 32'h0000_FFFF, 18, 22, "R2 c16hi");
    run_op(4'd5, 1'b1, 32'h0001_0000, 26, 30, "R2 c24lo");
    run_op(4'd6, 1'b1, 32'h00FF_FFFF, 26, 30, "R2 c24hi");
    run_op(4'd7, 1'b1, 32'h0100_0000, 34, 38, "R2 c32lo");
    run_op(4'd8, 1'b1, 32'hFFFF_FFFF, 34, 38, "R2 c32hi");
    test_busy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule